// File: doc/BRIEF.md
# SpaceWire Transmit DMA Engine

This block moves outgoing packets from system memory into the write side of a SpaceWire transmit FIFO. Packets are described by descriptors held in a table in memory. When the host raises the start input, the engine reads the descriptor at the current table index. If that descriptor is enabled, the engine fetches the packet buffer through a request/grant memory port and pushes every word toward the link. It then appends an end-of-packet control word, writes the descriptor back as consumed, raises a sticky packet-sent flag and steps to the next table slot.

Buffer words are staged in a 32-word local FIFO. Memory reads are issued in bursts of half the FIFO depth, and a burst starts only once the FIFO has drained to half or less. Two further cases are handled. A descriptor that is not enabled raises a no-descriptor flag and nothing is sent. An abort request empties the local FIFO and ends the packet with an error-end-of-packet control word.

Top module: `spw_txdma`

## Requirements
- R1: After reset, `pkt_done`, `tx_nodesc`, `spw_wr` and `mem_req` are low and `desc_idx` is 0.
- R2: Descriptor slot n sits at byte address {`tbl_base`, n, 4'h0}. Its first word is the control word: bit 31 is the enable bit and bits 23:0 are the byte length, of which bits 1:0 are ignored, so the word count is length>>2. The word at slot address + 4 is the buffer byte address.
- R3: Buffer words are pushed in address order, one per cycle at most, with `spw_ctl` low. `spw_wr` is never high while `spw_full` is high.
- R4: After the last buffer word, exactly one control word is pushed with `spw_ctl`=1 and `spw_dat`=0 (end of packet). `spw_ctl` is high only on terminating words.
- R5: The local FIFO holds 32 words and never overflows. A buffer read burst begins only when the FIFO holds 16 words or fewer.
- R6: On completion, the control word is written back to its slot with bit 31 cleared and all other bits kept. `pkt_done` rises the cycle after that write is granted.
- R7: `pkt_done` stays high until a one-cycle `clr_done` pulse clears it.
- R8: `desc_idx` advances by one after each completed packet and wraps from 63 to 0.
- R9: A descriptor read with bit 31 clear sets `tx_nodesc`, pushes nothing and leaves `desc_idx` unchanged. Reading an enabled descriptor clears `tx_nodesc`.
- R10: `abort_req` during a transfer empties the local FIFO and pushes a single control word with `spw_dat`=1 (error end of packet). It does not set `pkt_done`, does not advance `desc_idx` and does not write the descriptor.
- R11: A descriptor with a word count of zero sends only the end-of-packet control word, then completes as in R6 and R8.
- R12: While `mem_req` is high and not granted, and no abort is pending, `mem_req`, `mem_addr` and `mem_we` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_go | input | 1 | Host start: a packet is waiting |
| abort_req | input | 1 | Abort the packet in progress |
| clr_done | input | 1 | Register-write pulse clearing `pkt_done` |
| tbl_base | input | 22 | Descriptor table base (address bits 31:10) |
| tx_nodesc | output | 1 | Last descriptor read was not enabled |
| pkt_done | output | 1 | Sticky packet-sent flag |
| desc_idx | output | 6 | Current descriptor slot |
| spw_full | input | 1 | SpaceWire FIFO full |
| spw_wr | output | 1 | Push strobe toward SpaceWire |
| spw_ctl | output | 1 | Pushed word is a terminator |
| spw_dat | output | 32 | Pushed word; 0 = EOP, 1 = EEP when `spw_ctl` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid in the granted cycle |

## Verification
A memory read completes in the cycle it is granted. A granted buffer word can leave on `spw_wr` no earlier than the next cycle, and `pkt_done` is due one cycle after the descriptor write-back is granted. The memory and link models change their random grant and full inputs one time unit after each rising edge. The monitor reads every port at the falling edge, so each push, grant and flag is seen in the cycle it takes effect. Data order, the terminator code and the FIFO-occupancy limit at each burst start are checked against models the bench keeps itself. Flags are checked only after the bounded number of cycles that R6, R9 and R10 allow.

// File: rtl/spwtx_pkg.sv
package spwtx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTL,
      ST_PTR,
      ST_XFER,
      ST_EOP,
      ST_WB,
      ST_EEP
   } tx_st_t;

   localparam logic [31:0] TERM_EOP = 32'd0;
   localparam logic [31:0] TERM_EEP = 32'd1;
endpackage

// File: rtl/spwtx_fifo.sv
module spwtx_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] cnt
);
   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("spwtx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] rp, wp;

   always_ff @(posedge clk) begin
      if (push) store[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout = store[rp];
endmodule

// File: rtl/spwtx_flags.sv
module spwtx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_done,
   input  logic clr_done,
   input  logic desc_seen,
   input  logic desc_ok,
   output logic pkt_done,
   output logic nodesc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_done <= 1'b0;
         nodesc   <= 1'b0;
      end else begin
         if (set_done)      pkt_done <= 1'b1;
         else if (clr_done) pkt_done <= 1'b0;
         if (desc_seen)     nodesc   <= ~desc_ok;
      end
   end
endmodule

// File: rtl/spw_txdma.sv
module spw_txdma
   import spwtx_pkg::*;
#(
   parameter int DW     = 32,
   parameter int AW     = 32,
   parameter int BASE_W = 22,
   parameter int IDX_W  = 6,
   parameter int LEN_W  = 24,
   parameter int DEPTH  = 32,
   localparam int WL    = LEN_W - 2,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int HALF  = DEPTH / 2,
   localparam int BURST = DEPTH - HALF,
   localparam int BCW   = $clog2(BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_go,
   input  logic              abort_req,
   input  logic              clr_done,
   input  logic [BASE_W-1:0] tbl_base,
   output logic              tx_nodesc,
   output logic              pkt_done,
   output logic [IDX_W-1:0]  desc_idx,
   input  logic              spw_full,
   output logic              spw_wr,
   output logic              spw_ctl,
   output logic [DW-1:0]     spw_dat,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_gnt,
   input  logic [DW-1:0]     mem_rdata
);
   generate
      if (AW != BASE_W + IDX_W + 4) begin : g_bad_addr
         $error("spw_txdma: AW must equal BASE_W + IDX_W + 4");
      end
      if (DW != AW || LEN_W > DW - 1) begin : g_bad_data
         $error("spw_txdma: DW must equal AW and exceed LEN_W");
      end
   endgenerate

   tx_st_t          st;
   logic [WL-1:0]   fetch_left, push_left;
   logic [AW-1:0]   fetch_addr;
   logic [BCW-1:0]  burst_left;
   logic            in_burst;
   logic [DW-1:0]   ctl_word;
   logic [CW-1:0]   f_cnt;
   logic [DW-1:0]   f_dout;
   logic            f_push, f_pop, go_abort, start_burst, set_done, desc_seen;
   logic [AW-1:0]   slot_addr;

   assign slot_addr = {tbl_base, desc_idx, 4'h0};
   assign go_abort  = abort_req &&
                      (st == ST_CTL || st == ST_PTR || st == ST_XFER || st == ST_EOP);
   assign f_push    = (st == ST_XFER) && in_burst && mem_gnt && !go_abort;
   assign f_pop     = (st == ST_XFER) && (f_cnt != '0) && !spw_full && !go_abort;
   assign start_burst = (st == ST_XFER) && !in_burst && (fetch_left != '0) &&
                        (f_cnt <= CW'(HALF)) && !go_abort;
   assign set_done  = (st == ST_WB) && mem_gnt;
   assign desc_seen = (st == ST_CTL) && mem_gnt && !go_abort;

   spwtx_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(go_abort),
      .push(f_push), .din(mem_rdata), .pop(f_pop),
      .dout(f_dout), .cnt(f_cnt)
   );

   spwtx_flags u_flags (
      .clk(clk), .rst_n(rst_n), .set_done(set_done), .clr_done(clr_done),
      .desc_seen(desc_seen), .desc_ok(mem_rdata[DW-1]),
      .pkt_done(pkt_done), .nodesc(tx_nodesc)
   );

   // memory port
   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = slot_addr;
      case (st)
         ST_CTL:  mem_req = 1'b1;
         ST_PTR:  begin mem_req = 1'b1; mem_addr = slot_addr | AW'(4); end
         ST_WB:   begin mem_req = 1'b1; mem_we = 1'b1; end
         ST_XFER: begin mem_req = in_burst; mem_addr = fetch_addr; end
         default: ;
      endcase
   end
   assign mem_wdata = {1'b0, ctl_word[DW-2:0]};

   // link side
   always_comb begin
      spw_ctl = (st == ST_EOP) || (st == ST_EEP);
      spw_dat = f_dout;
      spw_wr  = f_pop;
      if (st == ST_EOP) begin
         spw_dat = TERM_EOP;
         spw_wr  = !spw_full && !go_abort;
      end else if (st == ST_EEP) begin
         spw_dat = TERM_EEP;
         spw_wr  = !spw_full;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         fetch_left <= '0;
         push_left  <= '0;
         fetch_addr <= '0;
         burst_left <= '0;
         in_burst   <= 1'b0;
         ctl_word   <= '0;
         desc_idx   <= '0;
      end else if (go_abort) begin
         st       <= ST_EEP;
         in_burst <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (tx_go) st <= ST_CTL;
            ST_CTL: if (mem_gnt) begin
               ctl_word   <= mem_rdata;
               fetch_left <= mem_rdata[LEN_W-1:2];
               push_left  <= mem_rdata[LEN_W-1:2];
               st         <= mem_rdata[DW-1] ? ST_PTR : ST_IDLE;
            end
            ST_PTR: if (mem_gnt) begin
               fetch_addr <= {mem_rdata[AW-1:2], 2'b00};
               in_burst   <= 1'b0;
               st         <= ST_XFER;
            end
            ST_XFER: begin
               if (start_burst) begin
                  in_burst   <= 1'b1;
                  burst_left <= BCW'(BURST);
               end
               if (f_push) begin
                  fetch_addr <= fetch_addr + AW'(4);
                  fetch_left <= fetch_left - 1'b1;
                  burst_left <= burst_left - 1'b1;
                  if (burst_left == BCW'(1) || fetch_left == WL'(1)) in_burst <= 1'b0;
               end
               if (f_pop) push_left <= push_left - 1'b1;
               if (push_left == '0) st <= ST_EOP;
            end
            ST_EOP: if (!spw_full) st <= ST_WB;
            ST_WB: if (mem_gnt) begin
               desc_idx <= desc_idx + 1'b1;
               st       <= ST_IDLE;
            end
            ST_EEP: if (!spw_full) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spwtx_chk.sv
module spwtx_chk #(
   parameter int DEPTH = 32,
   parameter int IDX_W = 6,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       abort_req,
   input logic                       clr_done,
   input logic                       pkt_done,
   input logic [IDX_W-1:0]           desc_idx,
   input logic                       spw_full,
   input logic                       spw_wr,
   input logic                       spw_ctl,
   input logic [DW-1:0]              spw_dat,
   input logic                       mem_req,
   input logic                       mem_we,
   input logic                       mem_gnt,
   input logic [AW-1:0]              mem_addr,
   input logic [$clog2(DEPTH+1)-1:0] f_cnt
);
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      f_cnt <= ($clog2(DEPTH+1))'(DEPTH));

   p_push_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
      spw_wr |-> !spw_full);

   p_term_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (spw_wr && spw_ctl) |-> (spw_dat <= DW'(1)));

   p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_done) |-> $past(mem_req && mem_we && mem_gnt));

   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && !clr_done) |=> pkt_done);

   p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_idx != $past(desc_idx)) |->
         (desc_idx == $past(desc_idx) + 1'b1) && $past(mem_we && mem_gnt));

   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && !abort_req) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind spw_txdma spwtx_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .abort_req(abort_req), .clr_done(clr_done),
   .pkt_done(pkt_done), .desc_idx(desc_idx), .spw_full(spw_full),
   .spw_wr(spw_wr), .spw_ctl(spw_ctl), .spw_dat(spw_dat),
   .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
   .mem_addr(mem_addr), .f_cnt(f_cnt)
);

// File: tb/tb_spw_txdma.sv
module tb_spw_txdma;
   localparam int CLK_P   = 10;
   localparam int WD_MAX  = 150000;
   localparam int TBL_W   = 256;           // word index of the table (base 1)
   localparam int BUF_W   = 512;           // first buffer word

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        tx_go = 1'b0, abort_req = 1'b0, clr_done = 1'b0;
   logic [21:0] tbl_base = 22'd1;
   logic        tx_nodesc, pkt_done, spw_wr, spw_ctl, mem_req, mem_we;
   logic [5:0]  desc_idx;
   logic        spw_full = 1'b0, mem_gnt = 1'b0;
   logic [31:0] spw_dat, mem_addr, mem_wdata, mem_rdata;

   logic [31:0] mem [0:2047];
   assign mem_rdata = mem[mem_addr[12:2]];

   spw_txdma dut (.*);

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int gnt_pct = 60, full_pct = 30;
   int got_n = 0, fetched = 0, exp_idx = 0;
   logic [31:0] got [0:255];
   bit term_seen = 0, prev_dreq = 0;
   logic [31:0] term_code = '0;

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= WD_MAX) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, WD_MAX);
         $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
         $finish;
      end
      #1;
      mem_gnt  = mem_req && (($urandom % 100) < gnt_pct);
      spw_full = (($urandom % 100) < full_pct);
   end

   // port monitor, falling edge
   always @(negedge clk) if (rst_n) begin
      bit dreq;
      if (spw_wr) begin
         if (spw_full) chk(0, "R3", "push while full", 1, 0);
         if (spw_ctl) begin term_seen = 1; term_code = spw_dat; end
         else if (got_n < 256) begin got[got_n] = spw_dat; got_n++; end
      end
      if (mem_req && mem_we && mem_gnt) mem[mem_addr[12:2]] = mem_wdata;
      dreq = mem_req && !mem_we && (mem_addr >= 32'h800);
      if (dreq && !prev_dreq)
         chk((fetched - got_n) <= 16, "R5", "burst start occupancy", fetched - got_n, 16);
      if (dreq && mem_gnt) begin
         chk((fetched - got_n) < 32, "R5", "fifo room", fetched - got_n, 31);
         fetched++;
      end
      prev_dreq = dreq;
   end

   task automatic pulse_go();
      @(posedge clk); #2 tx_go = 1'b1;
      @(posedge clk); #2 tx_go = 1'b0;
   endtask

   task automatic run_pkt(int nw, bit ready, int abort_at);
      int slot, bw, lowb, k;
      logic [31:0] cw;
      slot = TBL_W + exp_idx * 4;
      bw   = BUF_W + int'($urandom % (2048 - BUF_W - nw - 1));
      for (int i = 0; i < nw; i++) mem[bw + i] = $urandom;
      lowb = int'($urandom % 4);
      cw   = {ready, 7'($urandom), 24'(nw * 4 + lowb)};
      mem[slot]     = cw;
      mem[slot + 1] = 32'(bw * 4);
      got_n = 0; fetched = 0; term_seen = 0;
      pulse_go();
      if (!ready) begin
         k = 0;
         while (!tx_nodesc && k < 300) begin @(negedge clk); k++; end
         repeat (4) @(negedge clk);
         chk(tx_nodesc, "R9", "nodesc flag", tx_nodesc, 1);
         chk(got_n == 0 && !term_seen, "R9", "words pushed", got_n, 0);
         chk(desc_idx == 6'(exp_idx), "R9", "index kept", desc_idx, exp_idx);
         return;
      end
      if (abort_at >= 0) begin
         while (got_n < abort_at) @(posedge clk);
         #1 abort_req = 1'b1;
         @(posedge clk); #1 abort_req = 1'b0;
         while (!term_seen) @(negedge clk);
         repeat (30) @(negedge clk);
         chk(term_code == 32'd1, "R10", "terminator code", term_code, 1);
         chk(!pkt_done, "R10", "no packet-sent", pkt_done, 0);
         chk(desc_idx == 6'(exp_idx), "R10", "index kept", desc_idx, exp_idx);
         chk(mem[slot] == cw, "R10", "descriptor untouched", mem[slot], cw);
         k = 0;
         for (int i = 0; i < got_n; i++) if (got[i] != mem[bw + i]) k++;
         chk(k == 0 && got_n < nw, "R10", "prefix data", got_n, abort_at);
         return;
      end
      while (!term_seen) @(negedge clk);
      chk(term_code == 32'd0, "R4", "terminator code", term_code, 0);
      chk(got_n == nw, (nw == 0) ? "R11" : "R2", "word count", got_n, nw);
      k = 0;
      for (int i = 0; i < nw; i++) if (got[i] != mem[bw + i]) k++;
      chk(k == 0, "R3", "data order mismatches", k, 0);
      k = 0;
      while (!pkt_done && k < 300) begin @(negedge clk); k++; end
      chk(pkt_done, "R6", "packet-sent", pkt_done, 1);
      chk(mem[slot] == {1'b0, cw[30:0]}, "R6", "write-back", mem[slot], {1'b0, cw[30:0]});
      exp_idx = (exp_idx + 1) % 64;
      chk(desc_idx == 6'(exp_idx), "R8", "index step", desc_idx, exp_idx);
      chk(!tx_nodesc, "R9", "nodesc cleared", tx_nodesc, 0);
      repeat (3) @(negedge clk);
      chk(pkt_done, "R7", "flag held", pkt_done, 1);
      @(posedge clk); #1 clr_done = 1'b1;
      @(posedge clk); #1 clr_done = 1'b0;
      @(negedge clk);
      chk(!pkt_done, "R7", "flag cleared", pkt_done, 0);
   endtask

   initial begin
      void'($urandom(32'd20250611));
      for (int i = 0; i < 2048; i++) mem[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!pkt_done && !tx_nodesc && !spw_wr && !mem_req && desc_idx == 0,
          "R1", "reset outputs", {pkt_done, tx_nodesc, spw_wr, mem_req, desc_idx}, 0);
      // directed cases
      run_pkt(5, 1'b1, -1);
      run_pkt(0, 1'b0, -1);          // R9 not ready
      run_pkt(0, 1'b1, -1);          // R11 empty packet
      full_pct = 70;
      run_pkt(40, 1'b1, -1);         // R5 slow drain
      full_pct = 0; gnt_pct = 100;
      run_pkt(70, 1'b1, -1);         // R5 fast fetch
      full_pct = 50; gnt_pct = 60;
      run_pkt(80, 1'b1, 10);         // R10 abort
      run_pkt(3, 1'b1, -1);          // same slot again after abort
      // random phase, wraps the index (R8)
      for (int p = 0; p < 70; p++) begin
         int nw;
         gnt_pct  = 20 + int'($urandom % 81);
         full_pct = int'($urandom % 60);
         nw = int'($urandom % 61);
         if (($urandom % 10) == 0 && nw >= 20) run_pkt(nw, 1'b1, nw / 3);
         else if (($urandom % 12) == 0)        run_pkt(nw, 1'b0, -1);
         else                                  run_pkt(nw, 1'b1, -1);
      end
      repeat (5) @(posedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule